// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block is a two-stage SIMD multiplier for packed 16-bit results. Each cycle it can accept a pair of packed operands together with an operation select and a width select. It returns one packed result a fixed two cycles later. Back-to-back operations are accepted every cycle, and the operation may change from one cycle to the next.

It has two operations. The first is a Q1.15 fractional multiply with round-to-nearest. Each 16-bit word is a signed value from -1.0 up to just below +1.0. For example, 0x4000 is +0.5 and 0xA000 is -0.75. The second is a mixed-sign byte dot product. Unsigned bytes of A are multiplied by signed bytes of B, the two products in each word position are added, and the sum is clamped to the signed 16-bit range. The full operand is 128 bits. With the narrow select, only the low 64 bits of the result are produced.

The pipeline has no control states: each register stage holds either a valid operation or a bubble. Stage one (the product stage) forms a 32-bit word product and two 17-bit byte products per word position. Stage two (the finish stage) rounds or saturates them, and clears any word positions that are idle or masked.

Top module: `pfm_top`

## Requirements
- R1: While reset is asserted and immediately after it is released, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high exactly two clock cycles after an accepted `in_valid`, and low otherwise. Each accepted operation yields exactly one result.
- R3: With `in_op`=0 (fractional multiply), word k of the result (bits 16k+15:16k) equals (((a·b) >> 14) + 1) >> 1, keeping the low 16 bits. Here a and b are word k of A and of B, read as signed. Examples: 0x4000·0x4000 = 0x2000; 0x4000·0xA000 = 0xD000; 0x0001·0x4000 = 0x0001; 0xFFFF·0x4001 = 0xFFFF.
- R4: In fractional multiply, 0x8000·0x8000 yields 0x8000, which is the wrapped result and not a clamped one.
- R5: With `in_op`=1 (byte dot product), word k equals A[2k]·B[2k] + A[2k+1]·B[2k+1]. Byte j is bits 8j+7:8j, A bytes are unsigned and B bytes are signed.
- R6: In byte dot product, a pair sum above 32767 gives 0x7FFF and a pair sum below -32768 gives 0x8000.
- R7: With `in_wide`=0, result bits 127:64 are zero and bits 63:0 match the 128-bit result. With `in_wide`=1, all eight words are produced.
- R8: Operations issued on consecutive cycles with different operations and widths each give their own correct result, in issue order.
- R9: `out_data` is all zeros in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 1 | 0 = rounded Q1.15 multiply, 1 = byte dot product |
| in_wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit (low half only) |
| in_a | input | 128 | Operand A (signed words, or unsigned bytes) |
| in_b | input | 128 | Operand B (signed words, or signed bytes) |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 128 | Packed 16-bit results |

## Verification
The bench targets the rounding boundary, where a product just below half an LSB must round down and one at half must round up. It also checks the negative side, where a truncating design would return -1 instead of 0. The single overflow case 0x8000·0x8000 must wrap to 0x8000. A design that saturates would give 0x7FFF there, and a design that reads both byte operands as signed would fail the 255·127 and 255·-128 pairs on value and on saturation. Narrow operations check that no leftover upper-half data leaks out. Mixed streams check that the operation and width selects move in step with the data through both stages.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    typedef enum logic {
        OP_MULHR = 1'b0,
        OP_BDOT  = 1'b1
    } op_e;

    typedef struct packed {
        logic signed [31:0] wprod;
        logic signed [16:0] bp_lo;
        logic signed [16:0] bp_hi;
    } lane_prod_t;

endpackage

// File: rtl/pfm_lane_mul.sv
module pfm_lane_mul
    import pfm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [WORD_W-1:0] a_w,
    input  logic [WORD_W-1:0] b_w,
    output lane_prod_t        prod_q
);

    localparam int BYTE_W = WORD_W / 2;
    localparam int PW     = 2 * WORD_W;

    logic signed [PW-1:0] sa_ext, sb_ext;
    logic signed [16:0]   ua_lo, ua_hi, sb_lo, sb_hi;
    lane_prod_t           prod_d;

    always_comb begin
        sa_ext = {{WORD_W{a_w[WORD_W-1]}}, a_w};
        sb_ext = {{WORD_W{b_w[WORD_W-1]}}, b_w};
        ua_lo  = {{(17-BYTE_W){1'b0}}, a_w[BYTE_W-1:0]};
        ua_hi  = {{(17-BYTE_W){1'b0}}, a_w[WORD_W-1:BYTE_W]};
        sb_lo  = {{(17-BYTE_W){b_w[BYTE_W-1]}}, b_w[BYTE_W-1:0]};
        sb_hi  = {{(17-BYTE_W){b_w[WORD_W-1]}}, b_w[WORD_W-1:BYTE_W]};
        prod_d.wprod = sa_ext * sb_ext;
        prod_d.bp_lo = ua_lo * sb_lo;
        prod_d.bp_hi = ua_hi * sb_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (en) begin
            prod_q <= prod_d;
        end
    end

    // R4: the extreme negative pair must reach the finish stage as +2^30
    a_r4_extreme_product: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a_w == 16'h8000 && b_w == 16'h8000) |=> (prod_q.wprod == 32'sh4000_0000));

endmodule

// File: rtl/pfm_lane_fin.sv
module pfm_lane_fin
    import pfm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  op_e               op,
    input  logic              keep,
    input  lane_prod_t        prod,
    output logic [WORD_W-1:0] res_q
);

    localparam int PW = 2 * WORD_W;
    localparam logic signed [17:0] SAT_HI = 18'sd32767;
    localparam logic signed [17:0] SAT_LO = -18'sd32768;

    logic signed [PW:0]  rnd;
    logic [WORD_W-1:0]   hr_res;
    logic signed [17:0]  pair_sum;
    logic [WORD_W-1:0]   bd_res;
    logic [WORD_W-1:0]   res_d;

    always_comb begin
        rnd      = {prod.wprod[PW-1], prod.wprod} + (PW+1)'(33'sh4000);
        hr_res   = rnd[30:15];
        pair_sum = {prod.bp_lo[16], prod.bp_lo} + {prod.bp_hi[16], prod.bp_hi};
        if (pair_sum > SAT_HI) begin
            bd_res = 16'h7FFF;
        end else if (pair_sum < SAT_LO) begin
            bd_res = 16'h8000;
        end else begin
            bd_res = pair_sum[15:0];
        end
        if (!(vld && keep)) begin
            res_d = '0;
        end else begin
            unique case (op)
                OP_MULHR: res_d = hr_res;
                OP_BDOT:  res_d = bd_res;
                default:  res_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    // R6: clamp on positive overflow
    a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && keep && op == OP_BDOT && pair_sum > SAT_HI) |=> (res_q == 16'h7FFF));
    // R6: clamp on negative overflow
    a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && keep && op == OP_BDOT && pair_sum < SAT_LO) |=> (res_q == 16'h8000));
    // R4: extreme product wraps to 0x8000
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && keep && op == OP_MULHR && prod.wprod == 32'sh4000_0000) |=> (res_q == 16'h8000));

endmodule

// File: rtl/pfm_top.sv
module pfm_top
    import pfm_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int LANES = DATA_W / WORD_W;
    localparam int HALF  = LANES / 2;

    logic s1_valid;
    op_e  s1_op;
    logic s1_wide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_op     <= OP_MULHR;
            s1_wide   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
            if (in_valid) begin
                s1_op   <= op_e'(in_op);
                s1_wide <= in_wide;
            end
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            localparam bit UPPER = (g >= HALF);
            lane_prod_t prod;
            logic       keep;

            assign keep = !UPPER || s1_wide;

            pfm_lane_mul #(.WORD_W(WORD_W)) u_mul (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (in_valid),
                .a_w    (in_a[g*WORD_W +: WORD_W]),
                .b_w    (in_b[g*WORD_W +: WORD_W]),
                .prod_q (prod)
            );

            pfm_lane_fin #(.WORD_W(WORD_W)) u_fin (
                .clk   (clk),
                .rst_n (rst_n),
                .vld   (s1_valid),
                .op    (s1_op),
                .keep  (keep),
                .prod  (prod),
                .res_q (out_data[g*WORD_W +: WORD_W])
            );
        end
    endgenerate

    // R2: each stage passes its valid on exactly one cycle later
    a_r2_stage1_on: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    a_r2_stage1_off: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !s1_valid);
    a_r2_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    // R9: an idle output carries no data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));
    // R7: a narrow operation leaves the upper half clear
    a_r7_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_wide) |=> (out_data[DATA_W-1:DATA_W/2] == '0));

endmodule

// File: tb/sim_pfm_top.sv
module sim_pfm_top;

    localparam int DW = 128;
    localparam int NL = DW / 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_op = 1'b0;
    logic          in_wide = 1'b0;
    logic [DW-1:0] in_a = '0;
    logic [DW-1:0] in_b = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pfm_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] m_hr(input logic [15:0] a, input logic [15:0] b);
        longint p, r;
        p = longint'($signed(a)) * longint'($signed(b));
        r = ((p >>> 14) + 1) >>> 1;
        return r[15:0];
    endfunction

    function automatic logic [15:0] m_bd(input logic [15:0] a, input logic [15:0] b);
        int s;
        s = int'(a[7:0]) * int'($signed(b[7:0])) + int'(a[15:8]) * int'($signed(b[15:8]));
        if (s > 32767) return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return s[15:0];
    endfunction

    function automatic logic [DW-1:0] m_vec(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic op, input logic wide);
        logic [DW-1:0] r = '0;
        for (int k = 0; k < NL; k++) begin
            if (wide || k < NL / 2)
                r[k*16 +: 16] = op ? m_bd(a[k*16 +: 16], b[k*16 +: 16])
                                   : m_hr(a[k*16 +: 16], b[k*16 +: 16]);
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // drive one op at a negedge, verify valid timing and data two edges later
    task automatic run_one(input string tag, input logic [DW-1:0] a, input logic [DW-1:0] b,
                           input logic op, input logic wide);
        @(negedge clk);
        in_a = a; in_b = b; in_op = op; in_wide = wide; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_a = ~a; in_b = ~b;
        chk("R2 early", {127'b0, out_valid}, '0);
        @(negedge clk);
        chk("R2 valid", {127'b0, out_valid}, {127'b0, 1'b1});
        chk(tag, out_data, m_vec(a, b, op, wide));
        @(negedge clk);
        chk("R2 single", {127'b0, out_valid}, '0);
        chk("R9 idle", out_data, '0);
    endtask

    task automatic t_reset();
        chk("R1 valid", {127'b0, out_valid}, '0);
        chk("R1 data", out_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after", {out_data[126:0], out_valid}, '0);
    endtask

    task automatic t_q15();
        logic [DW-1:0] a, b;
        a = {16'h4000, 16'h4000, 16'h0001, 16'h0001, 16'hFFFF, 16'hFFFF, 16'h7FFF, 16'h0000};
        b = {16'h4000, 16'hA000, 16'h4000, 16'h3FFF, 16'h4000, 16'h4001, 16'h7FFF, 16'h1234};
        run_one("R3 points", a, b, 1'b0, 1'b1);
        chk("R3 literal", m_vec(a, b, 1'b0, 1'b1),
            {16'h2000, 16'hD000, 16'h0001, 16'h0000, 16'h0000, 16'hFFFF, 16'h7FFE, 16'h0000});
        for (int i = 0; i < 3; i++)
            run_one("R3 random", {$urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom, $urandom, $urandom}, 1'b0, 1'b1);
    endtask

    task automatic t_wrap();
        run_one("R4 wrap", {NL{16'h8000}}, {NL{16'h8000}}, 1'b0, 1'b1);
        chk("R4 literal", m_vec({NL{16'h8000}}, {NL{16'h8000}}, 1'b0, 1'b1), {NL{16'h8000}});
    endtask

    task automatic t_bdot();
        logic [DW-1:0] a, b;
        a = {16'h02FF, 16'h0101, 16'h8080, 16'h0003, 16'hFF01, 16'h1020, 16'h0000, 16'h0505};
        b = {16'h0301, 16'hFFFF, 16'h0101, 16'h00FE, 16'h0280, 16'h7F7F, 16'h7F7F, 16'h80FB};
        run_one("R5 pattern", a, b, 1'b1, 1'b1);
        run_one("R5 random", {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, 1'b1, 1'b1);
    endtask

    task automatic t_sat();
        logic [DW-1:0] a, b;
        a = {NL{16'hFFFF}};
        b = {16'h7F7F, 16'h8080, 16'h7F7F, 16'h8080, 16'h7F7E, 16'h8081, 16'h7F00, 16'h0080};
        run_one("R6 clamp", a, b, 1'b1, 1'b1);
        chk("R6 literal", m_vec(a, b, 1'b1, 1'b1)[127:96], {16'h7FFF, 16'h8000});
    endtask

    task automatic t_narrow();
        logic [DW-1:0] a, b;
        a = {$urandom, $urandom, $urandom, $urandom};
        b = {$urandom, $urandom, $urandom, $urandom};
        run_one("R7 narrow mul", a, b, 1'b0, 1'b0);
        run_one("R7 narrow dot", a, b, 1'b1, 1'b0);
    endtask

    task automatic t_stream();
        logic [DW-1:0] ea [6];
        logic [DW-1:0] a, b;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R8 stream valid", {127'b0, out_valid}, {127'b0, 1'b1});
                chk("R8 stream data", out_data, ea[i-2]);
            end
            if (i < 6) begin
                a = {$urandom, $urandom, $urandom, $urandom};
                b = {$urandom, $urandom, $urandom, $urandom};
                if (i == 3) begin a = {NL{16'h8000}}; b = {NL{16'h8000}}; end
                in_a = a; in_b = b; in_op = i[0]; in_wide = ~i[1]; in_valid = 1'b1;
                ea[i] = m_vec(a, b, i[0], ~i[1]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R9 drained", {out_data[126:0], out_valid}, '0);
    endtask

    initial begin
        #(8 * 50000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        #1;
        t_reset();
        t_q15();
        t_wrap();
        t_bdot();
        t_sat();
        t_narrow();
        t_stream();
        finish_up();
    end

endmodule